// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Write Permission

This block turns a virtual address into a physical address. It keeps a small table of recent page mappings and searches every slot at once. Pages are 4 KB, so the low twelve address bits are the page offset and pass through unchanged. The upper twenty bits form the virtual page number, which is looked up. A hit joins the stored 18-bit physical page number to the offset, giving a 30-bit physical address. The result is available combinationally in the same cycle as the request.

Each slot also carries a write-permit flag. A write that lands on a slot whose flag is clear produces no translation and raises a protection exception. A lookup that finds no valid slot raises a miss exception.

After a miss, the surrounding logic loads the missing mapping through the fill port. The fill goes into the lowest-numbered empty slot. When no slot is empty, a rotating pointer chooses the slot to replace. A flush input empties the whole table in one cycle.

Top module: `xlat_buffer`

## Requirements
- R1: A read or write request whose page number matches a valid slot that permits the access drives `resp_hit`=1 and `resp_paddr` = {stored 18-bit page number, `req_vaddr[11:0]`} in the same cycle as the request.
- R2: A request whose page number (`req_vaddr[31:12]`) matches no valid slot drives `miss_exc`=1, `resp_hit`=0 and `resp_paddr`=0.
- R3: A write request (`req_write`=1) that matches a slot whose write-permit flag is 0 drives `wprot_exc`=1, `resp_hit`=0 and `resp_paddr`=0. A read of that same slot still hits.
- R4: A fill (`fill_en`=1 at a rising edge, no flush) goes into the lowest-numbered invalid slot and can be looked up from the next cycle.
- R5: When every slot is valid, a fill replaces the slot at a rotating pointer. The pointer is 0 after reset, advances by one for each replacement only, and wraps from ENTRIES-1 to 0. A flush does not move it.
- R6: `flush`=1 at a rising edge invalidates every slot, so later lookups miss. A fill in the same cycle as a flush is ignored.
- R7: When several valid slots hold the same page number, the lowest-numbered one supplies the translation and the permission.
- R8: With `req_valid`=0, `resp_hit`, `miss_exc` and `wprot_exc` are 0 and `resp_paddr` is 0.
- R9: After reset every slot is invalid, so any lookup misses.
- R10: At most one of `resp_hit`, `miss_exc`, `wprot_exc` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| resp_hit | output | 1 | Translation delivered |
| resp_paddr | output | 30 | Translated physical address (0 unless hit) |
| miss_exc | output | 1 | No valid slot matched |
| wprot_exc | output | 1 | Write to a slot without write permission |
| fill_en | input | 1 | Load a mapping at this edge |
| fill_vpn | input | 20 | Virtual page number to load |
| fill_ppn | input | 18 | Physical page number to load |
| fill_wr_ok | input | 1 | Write-permit flag to load |
| flush | input | 1 | Invalidate every slot |

## Verification
The bench builds the block with ENTRIES=4 and the default address widths. With only four slots, a handful of fills is enough to fill the table, force replacements and walk the rotating pointer through a full wrap. The same small table lets a replacement create a duplicate page number in a lower slot than an existing one, which exercises the lowest-slot-wins rule. Permission and miss checks do not depend on table size, so they run on the same build.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      RK_IDLE  = 2'd0,
      RK_HIT   = 2'd1,
      RK_MISS  = 2'd2,
      RK_WPROT = 2'd3
   } resp_kind_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter int ENTRIES = 32,
   parameter int VPN_W   = 20,
   parameter int IDX_W   = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ENTRIES-1:0]             slot_valid,
   input  logic [ENTRIES-1:0][VPN_W-1:0]  slot_tag,
   input  logic [VPN_W-1:0]               look_vpn,
   output logic                           hit_any,
   output logic [IDX_W-1:0]               hit_idx
);
   logic [ENTRIES-1:0] eq;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign eq[g] = slot_valid[g] && (slot_tag[g] == look_vpn);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (eq[i]) hit_idx = IDX_W'(i);
      end
   end

   assign hit_any = |eq;

   // the chosen slot must match, and no lower slot may match
   assert_lowest_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_any |-> (eq[hit_idx] &&
                   ((eq & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0)));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int ENTRIES = 32,
   parameter int IDX_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] slot_valid,
   input  logic               take,
   output logic [IDX_W-1:0]   victim_idx
);
   localparam bit POW2 = (ENTRIES == (1 << IDX_W));

   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] free_idx;
   logic             has_free;
   logic [IDX_W-1:0] rr_next;

   always_comb begin
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!slot_valid[i]) free_idx = IDX_W'(i);
      end
   end

   assign has_free   = ~&slot_valid;
   assign victim_idx = has_free ? free_idx : rr_q;

   if (POW2) begin : g_wrap_natural
      assign rr_next = rr_q + IDX_W'(1);
   end else begin : g_wrap_compare
      assign rr_next = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                rr_q <= '0;
      else if (take && !has_free) rr_q <= rr_next;
   end

   assert_free_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      has_free |-> !slot_valid[victim_idx]);

   assert_ptr_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !has_free) |=> (rr_q != $past(rr_q)));

   assert_ptr_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!take || has_free) |=> $stable(rr_q));
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
   import xlat_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int PA_W      = 30,
   parameter int ENTRIES   = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [VA_W-1:0]            req_vaddr,
   input  logic                       req_write,
   output logic                       resp_hit,
   output logic [PA_W-1:0]            resp_paddr,
   output logic                       miss_exc,
   output logic                       wprot_exc,
   input  logic                       fill_en,
   input  logic [VA_W-PAGE_BITS-1:0]  fill_vpn,
   input  logic [PA_W-PAGE_BITS-1:0]  fill_ppn,
   input  logic                       fill_wr_ok,
   input  logic                       flush
);
   localparam int VPN_W = VA_W - PAGE_BITS;
   localparam int PPN_W = PA_W - PAGE_BITS;
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $fatal(1, "xlat_buffer: ENTRIES must be at least 2");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= PA_W || PAGE_BITS >= VA_W) begin : g_bad_page
      $fatal(1, "xlat_buffer: PAGE_BITS must be below both address widths");
   end

   logic [ENTRIES-1:0]             valid_q;
   logic [ENTRIES-1:0][VPN_W-1:0]  tag_q;
   logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
   logic [ENTRIES-1:0]             wok_q;

   logic [VPN_W-1:0] look_vpn;
   logic             hit_any;
   logic [IDX_W-1:0] hit_idx;
   logic [IDX_W-1:0] victim_idx;
   logic             do_fill;
   resp_kind_e       kind;

   assign look_vpn = req_vaddr[VA_W-1:PAGE_BITS];
   assign do_fill  = fill_en && !flush;

   xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_match (
      .clk(clk), .rst_n(rst_n), .slot_valid(valid_q), .slot_tag(tag_q),
      .look_vpn(look_vpn), .hit_any(hit_any), .hit_idx(hit_idx)
   );

   xlat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
      .clk(clk), .rst_n(rst_n), .slot_valid(valid_q), .take(do_fill),
      .victim_idx(victim_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       valid_q <= '0;
      else if (flush)   valid_q <= '0;
      else if (fill_en) valid_q[victim_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_fill) begin
         tag_q[victim_idx] <= fill_vpn;
         ppn_q[victim_idx] <= fill_ppn;
         wok_q[victim_idx] <= fill_wr_ok;
      end
   end

   always_comb begin
      if (!req_valid)                         kind = RK_IDLE;
      else if (!hit_any)                      kind = RK_MISS;
      else if (req_write && !wok_q[hit_idx])  kind = RK_WPROT;
      else                                    kind = RK_HIT;
   end

   assign resp_hit   = (kind == RK_HIT);
   assign miss_exc   = (kind == RK_MISS);
   assign wprot_exc  = (kind == RK_WPROT);
   assign resp_paddr = resp_hit ? {ppn_q[hit_idx], req_vaddr[PAGE_BITS-1:0]} : '0;

   assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      resp_hit |-> (resp_paddr[PAGE_BITS-1:0] == req_vaddr[PAGE_BITS-1:0]));

   assert_miss_no_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      miss_exc |-> (resp_paddr == '0 && !hit_any));

   assert_wprot_is_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wprot_exc |-> (req_write && resp_paddr == '0));

   assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));

   assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!resp_hit && !miss_exc && !wprot_exc && resp_paddr == '0));

   assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({resp_hit, miss_exc, wprot_exc}));
endmodule

// File: tb/xlat_buffer_bench.sv
module xlat_buffer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N_ENT      = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        resp_hit;
   logic [29:0] resp_paddr;
   logic        miss_exc;
   logic        wprot_exc;
   logic        fill_en = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [17:0] fill_ppn = '0;
   logic        fill_wr_ok = 1'b0;
   logic        flush = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xlat_buffer #(.ENTRIES(N_ENT)) u_xlat_buffer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_write(req_write), .resp_hit(resp_hit), .resp_paddr(resp_paddr),
      .miss_exc(miss_exc), .wprot_exc(wprot_exc), .fill_en(fill_en),
      .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_wr_ok(fill_wr_ok),
      .flush(flush)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // kind: 1 hit, 2 miss, 3 write-protect
   task automatic look(input string req, input logic [31:0] va, input logic wr,
                       input int kind, input logic [17:0] ppn);
      logic [31:0] exp_pa;
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = va;
      req_write = wr;
      #1;
      exp_pa = (kind == 1) ? {2'b00, ppn, va[11:0]} : 32'h0;
      chk(req, "hit",   {31'h0, resp_hit},  {31'h0, kind == 1});
      chk(req, "miss",  {31'h0, miss_exc},  {31'h0, kind == 2});
      chk(req, "wprot", {31'h0, wprot_exc}, {31'h0, kind == 3});
      chk(req, "paddr", {2'b00, resp_paddr}, exp_pa);
      req_valid = 1'b0;
   endtask

   task automatic load(input logic [19:0] vpn, input logic [17:0] ppn, input logic wok);
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_wr_ok = wok;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic t_reset;
      look("R9", 32'h0000_0abc, 1'b0, 2, '0);
      look("R9", 32'hffff_f123, 1'b1, 2, '0);
   endtask

   task automatic t_fill_and_replace;
      for (int i = 0; i < N_ENT; i++) load(20'h10 + 20'(i), 18'h100 + 18'(i), 1'b1);
      look("R1", 32'h0001_0345, 1'b0, 1, 18'h100);
      look("R1", 32'h0001_3fff, 1'b1, 1, 18'h103);
      // first replacement goes to slot 0; duplicates page 0x13 held in slot 3
      load(20'h13, 18'h3aaaa, 1'b1);
      look("R5", 32'h0001_0000, 1'b0, 2, '0);
      look("R7", 32'h0001_3010, 1'b0, 1, 18'h3aaaa);
      load(20'h20, 18'h200, 1'b1);                  // slot 1
      look("R5", 32'h0001_1000, 1'b0, 2, '0);
      look("R5", 32'h0002_0777, 1'b0, 1, 18'h200);
      load(20'h21, 18'h201, 1'b1);                  // slot 2
      look("R5", 32'h0001_2000, 1'b0, 2, '0);
      load(20'h22, 18'h202, 1'b1);                  // slot 3
      look("R7", 32'h0001_3001, 1'b0, 1, 18'h3aaaa);
      load(20'h23, 18'h203, 1'b1);                  // wraps to slot 0
      look("R5", 32'h0001_3001, 1'b0, 2, '0);
      look("R5", 32'h0002_3abc, 1'b0, 1, 18'h203);
   endtask

   task automatic t_flush;
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      look("R6", 32'h0002_0000, 1'b0, 2, '0);
      look("R6", 32'h0002_3000, 1'b0, 2, '0);
      @(negedge clk);
      flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h44; fill_ppn = 18'h44; fill_wr_ok = 1'b1;
      @(negedge clk);
      flush = 1'b0; fill_en = 1'b0;
      look("R6", 32'h0004_4000, 1'b0, 2, '0);
   endtask

   task automatic t_lowest_free;
      load(20'h55, 18'h111, 1'b1);
      load(20'h55, 18'h222, 1'b0);
      look("R4", 32'h0005_5123, 1'b1, 1, 18'h111);
   endtask

   task automatic t_permission;
      load(20'h77, 18'h333, 1'b0);
      look("R3", 32'h0007_7456, 1'b1, 3, '0);
      look("R3", 32'h0007_7456, 1'b0, 1, 18'h333);
      load(20'h78, 18'h0abcd, 1'b1);
      look("R1", 32'h0007_8fed, 1'b1, 1, 18'h0abcd);
   endtask

   task automatic t_idle;
      @(negedge clk);
      req_valid = 1'b0; req_vaddr = 32'h0007_7456; req_write = 1'b1;
      #1;
      chk("R8", "quiet", {28'h0, resp_hit, miss_exc, wprot_exc, |resp_paddr}, 32'h0);
      req_vaddr = 32'h0009_9000;
      #1;
      chk("R8", "quiet miss", {29'h0, resp_hit, miss_exc, wprot_exc}, 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_bad++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill_and_replace();
      t_flush();
      t_lowest_free();
      t_permission();
      t_idle();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule